// File: doc/BRIEF.md
# Register-Write Command DMA Engine

This block plays back a queue of register-write commands held in memory. Software puts the commands into a buffer, sets the engine's enable, loads a start pointer and then a stop pointer. Writing the stop pointer starts the run. The engine reads 32-bit words one at a time from the start pointer up to the stop pointer, decodes them and issues writes on a local register write port. This moves batches of display register programming off the host. The engine never reads a register.

Commands are word pairs that start on even word indexes. A single write holds the data word first and then a header. A repeated write holds a count word, then a header, then that many data words, all sent to one register offset. An odd count is padded with one extra word. A pair whose header opcode is zero does nothing, so the zero fill up to the line-aligned stop pointer is harmless. An unknown opcode halts the run and raises a sticky error.

Top module: `regwr_dma`

## Requirements
- R1: After reset, busy, err, mem_req_valid and rw_valid are all 0.
- R2: A tail write starts a run only when it arrives while idle with the engine enabled, err clear, and the word-aligned value different from head. The run then sets busy and reads every word from head upward in steps of 4 bytes until head equals tail. Busy then drops.
- R3: A header whose opcode (bits 31:24) is 0x01 produces one write. The address is header bits 19:0, the byte enables are header bits 23:20, and the data is the word before the header.
- R4: A header with opcode 0x09 uses the word before it as a count N and bits 19:0 as the offset. The next N words are each written in order to that offset with byte enables 4'hF. When N is odd, one further word is skipped. N = 0 writes nothing.
- R5: A header with opcode 0x00 is skipped with no write, and decoding continues at the next pair.
- R6: Any other opcode sets err, makes no write, stops further reads and clears busy. err stays set, and blocks new runs, until the enable is written with 0 while idle.
- R7: Writes to enable, head or tail made while busy is high change nothing.
- R8: A tail write while disabled, or one equal to head, leaves busy low and issues no memory request.
- R9: The memory port has at most one read outstanding. A request holds its word-aligned address stable until it is accepted.
- R10: Register writes appear only while busy is high. The engine has no read path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_wr | input | 1 | Strobe to load the enable bit |
| en_val | input | 1 | Enable value loaded by en_wr |
| head_wr | input | 1 | Strobe to load the head (start) pointer from ptr_val |
| tail_wr | input | 1 | Strobe to load the tail (stop) pointer from ptr_val; may start a run |
| ptr_val | input | PTR_W | Byte pointer value; the low two bits are dropped |
| busy | output | 1 | A run is in progress |
| err | output | 1 | Sticky unknown-opcode flag |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | PTR_W | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Read data word |
| rw_valid | output | 1 | Register write strobe |
| rw_addr | output | 20 | Register offset |
| rw_data | output | 32 | Register write data |
| rw_be | output | 4 | Byte enables |

## Verification
The assertions assume a well-behaved memory. It returns exactly one data strobe for each accepted request, never in the same cycle as the acceptance, and sends no strobe when nothing is outstanding. The bench memory model answers one cycle after each accepted request, or stays silent. A stall mode holds ready low for three of every four cycles, which puts back-pressure on the request path. The assertions also assume the host pulses its control strobes only from a clean reset. The bench drives those strobes for exactly one cycle on falling edges.

// File: rtl/regwr_dma_pkg.sv
// Shared constants and types for the register-write command DMA engine.
// Assumes 32-bit command words with a fixed header layout.
package regwr_dma_pkg;
    localparam int WORD_W  = 32;
    localparam int OFS_W   = 20;
    localparam int BE_W    = 4;
    localparam int OPC_LSB = 24;
    localparam int BE_LSB  = 20;

    localparam logic [7:0] OPC_NOP     = 8'h00;
    localparam logic [7:0] OPC_DIRECT  = 8'h01;
    localparam logic [7:0] OPC_INDEXED = 8'h09;

    // Position of the next incoming word inside the current command
    typedef enum logic [1:0] {
        PH_FIRST  = 2'd0,
        PH_HEADER = 2'd1,
        PH_DATA   = 2'd2,
        PH_PAD    = 2'd3
    } phase_e;
endpackage

// File: rtl/regwr_dma_ctrl.sv
// Control state: enable, head/tail pointers, run flag and sticky error.
// Host writes are accepted only while idle. Head advances by one word for
// every accepted read response. Assumes pointers are byte addresses.
module regwr_dma_ctrl #(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic             en_val,
    input  logic             head_wr,
    input  logic             tail_wr,
    input  logic [PTR_W-1:0] ptr_val,
    input  logic             word_acc,
    input  logic             outst,
    input  logic             bad_op,
    output logic [PTR_W-1:0] head_q,
    output logic [PTR_W-1:0] tail_q,
    output logic             run_q,
    output logic             err_q,
    output logic             start
);
    localparam logic [PTR_W-1:0] WORD_STEP = PTR_W'(4);
    localparam logic [PTR_W-1:0] ALIGN_MSK = ~PTR_W'(3);

    logic             en_q;
    logic [PTR_W-1:0] ptr_al;
    logic             idle;
    logic             drained;

    // Decode host access conditions
    always_comb begin
        ptr_al  = ptr_val & ALIGN_MSK;
        idle    = !run_q;
        start   = tail_wr && idle && en_q && !err_q && (ptr_al != head_q);
        drained = run_q && (head_q == tail_q) && !outst;
    end

    // Enable bit, written only while idle
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (en_wr && idle)
            en_q <= en_val;
    end

    // Head pointer: host load when idle, else step per fetched word
    always_ff @(posedge clk) begin
        if (!rst_n)
            head_q <= '0;
        else if (head_wr && idle)
            head_q <= ptr_al;
        else if (word_acc)
            head_q <= head_q + WORD_STEP;
    end

    // Tail pointer, written only while idle
    always_ff @(posedge clk) begin
        if (!rst_n)
            tail_q <= '0;
        else if (tail_wr && idle)
            tail_q <= ptr_al;
    end

    // Run flag: set on start, cleared on drain or on a bad opcode
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else if (bad_op)
            run_q <= 1'b0;
        else if (start)
            run_q <= 1'b1;
        else if (drained)
            run_q <= 1'b0;
    end

    // Sticky error, cleared by disabling while idle
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (bad_op)
            err_q <= 1'b1;
        else if (en_wr && idle && !en_val)
            err_q <= 1'b0;
    end
endmodule

// File: rtl/regwr_dma_fetch.sv
// Word fetcher with a single outstanding read. Requests the word at head
// while a run is active and head differs from tail. Assumes the memory sends
// one data strobe per accepted request, no earlier than the next cycle.
module regwr_dma_fetch #(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PTR_W-1:0] head,
    input  logic [PTR_W-1:0] tail,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [PTR_W-1:0] req_addr,
    input  logic             rsp_valid,
    output logic             word_v,
    output logic             outst_q
);
    // Request generation and response qualification
    always_comb begin
        req_valid = run && !outst_q && (head != tail);
        req_addr  = head;
        word_v    = rsp_valid && outst_q;
    end

    // Outstanding-read tracker
    always_ff @(posedge clk) begin
        if (!rst_n)
            outst_q <= 1'b0;
        else if (req_valid && req_ready)
            outst_q <= 1'b1;
        else if (word_v)
            outst_q <= 1'b0;
    end
endmodule

// File: rtl/regwr_dma_decode.sv
// Command decoder: walks each fetched word through the command layout and
// drives the registered register-write port. Assumes words arrive in queue
// order and that a start pulse never coincides with an incoming word.
module regwr_dma_decode
    import regwr_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              word_v,
    input  logic [WORD_W-1:0] word,
    output logic              rw_valid,
    output logic [OFS_W-1:0]  rw_addr,
    output logic [WORD_W-1:0] rw_data,
    output logic [BE_W-1:0]   rw_be,
    output logic              bad_op
);
    phase_e            ph_q;
    logic [WORD_W-1:0] first_q;
    logic [WORD_W-1:0] left_q;
    logic [OFS_W-1:0]  ofs_q;
    logic              odd_q;
    logic [7:0]        opc;
    logic              known;

    // Header field extraction and opcode check
    always_comb begin
        opc    = word[WORD_W-1:OPC_LSB];
        known  = (opc == OPC_NOP) || (opc == OPC_DIRECT) || (opc == OPC_INDEXED);
        bad_op = word_v && (ph_q == PH_HEADER) && !known;
    end

    // Command phase sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= PH_FIRST;
            first_q <= '0;
            left_q  <= '0;
            ofs_q   <= '0;
            odd_q   <= 1'b0;
        end else if (start) begin
            ph_q <= PH_FIRST;
        end else if (word_v) begin
            unique case (ph_q)
                PH_FIRST: begin
                    first_q <= word;
                    ph_q    <= PH_HEADER;
                end
                PH_HEADER: begin
                    ph_q <= PH_FIRST;
                    if (opc == OPC_INDEXED) begin
                        ofs_q  <= word[OFS_W-1:0];
                        left_q <= first_q;
                        odd_q  <= first_q[0];
                        if (first_q != '0)
                            ph_q <= PH_DATA;
                    end
                end
                PH_DATA: begin
                    left_q <= left_q - 1'b1;
                    if (left_q == WORD_W'(1))
                        ph_q <= odd_q ? PH_PAD : PH_FIRST;
                end
                PH_PAD: ph_q <= PH_FIRST;
            endcase
        end
    end

    // Registered register-write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rw_valid <= 1'b0;
            rw_addr  <= '0;
            rw_data  <= '0;
            rw_be    <= '0;
        end else begin
            rw_valid <= 1'b0;
            if (word_v && ph_q == PH_HEADER && opc == OPC_DIRECT) begin
                rw_valid <= 1'b1;
                rw_addr  <= word[OFS_W-1:0];
                rw_data  <= first_q;
                rw_be    <= word[OPC_LSB-1:BE_LSB];
            end else if (word_v && ph_q == PH_DATA) begin
                rw_valid <= 1'b1;
                rw_addr  <= ofs_q;
                rw_data  <= word;
                rw_be    <= '1;
            end
        end
    end
endmodule

// File: rtl/regwr_dma.sv
// Top of the register-write command DMA engine. Connects control, fetch and
// decode. Assumes the host follows enable, head, tail ordering and that the
// queue is laid out in even-word-aligned commands up to tail.
module regwr_dma
    import regwr_dma_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic              en_val,
    input  logic              head_wr,
    input  logic              tail_wr,
    input  logic [PTR_W-1:0]  ptr_val,
    output logic              busy,
    output logic              err,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PTR_W-1:0]  mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              rw_valid,
    output logic [OFS_W-1:0]  rw_addr,
    output logic [WORD_W-1:0] rw_data,
    output logic [BE_W-1:0]   rw_be
);
    logic [PTR_W-1:0] head_q;
    logic [PTR_W-1:0] tail_q;
    logic             run_q;
    logic             err_q;
    logic             start;
    logic             word_v;
    logic             outst;
    logic             bad_op;

    regwr_dma_ctrl #(.PTR_W(PTR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (en_wr),
        .en_val   (en_val),
        .head_wr  (head_wr),
        .tail_wr  (tail_wr),
        .ptr_val  (ptr_val),
        .word_acc (word_v),
        .outst    (outst),
        .bad_op   (bad_op),
        .head_q   (head_q),
        .tail_q   (tail_q),
        .run_q    (run_q),
        .err_q    (err_q),
        .start    (start)
    );

    regwr_dma_fetch #(.PTR_W(PTR_W)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_q),
        .head      (head_q),
        .tail      (tail_q),
        .req_valid (mem_req_valid),
        .req_ready (mem_req_ready),
        .req_addr  (mem_req_addr),
        .rsp_valid (mem_rsp_valid),
        .word_v    (word_v),
        .outst_q   (outst)
    );

    regwr_dma_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .word_v   (word_v),
        .word     (mem_rsp_data),
        .rw_valid (rw_valid),
        .rw_addr  (rw_addr),
        .rw_data  (rw_data),
        .rw_be    (rw_be),
        .bad_op   (bad_op)
    );

    // Status outputs
    always_comb begin
        busy = run_q;
        err  = err_q;
    end
endmodule

// File: rtl/regwr_dma_chk.sv
// Protocol checker for regwr_dma, bound to every instance of the top.
// Assumes a memory that answers each accepted request exactly once.
module regwr_dma_chk #(
    parameter int PTR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_wr,
    input logic             en_val,
    input logic             busy,
    input logic             err,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PTR_W-1:0] mem_req_addr,
    input logic             rw_valid
);
    // R9
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);
    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    // R9
    req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));
    // R10
    write_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rw_valid |-> busy);
    // R2
    req_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);
    // R6
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);
    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(en_wr && !en_val)) |=> err);
endmodule

bind regwr_dma regwr_dma_chk #(.PTR_W(PTR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_wr         (en_wr),
    .en_val        (en_val),
    .busy          (busy),
    .err           (err),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .rw_valid      (rw_valid)
);

// File: tb/test_regwr_dma.sv
module test_regwr_dma;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_wr = 1'b0, en_val = 1'b0, head_wr = 1'b0, tail_wr = 1'b0;
    logic [PW-1:0] ptr_val = '0;
    logic          busy, err;
    logic          mem_req_valid, mem_req_ready;
    logic [PW-1:0] mem_req_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [31:0]   mem_rsp_data = '0;
    logic          rw_valid;
    logic [19:0]   rw_addr;
    logic [31:0]   rw_data;
    logic [3:0]    rw_be;

    always #2 clk = ~clk;

    regwr_dma #(.PTR_W(PW)) i_regwr_dma (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_val(en_val),
        .head_wr(head_wr), .tail_wr(tail_wr), .ptr_val(ptr_val),
        .busy(busy), .err(err),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rw_valid(rw_valid), .rw_addr(rw_addr),
        .rw_data(rw_data), .rw_be(rw_be)
    );

    // Memory model: 64 words, answers one cycle after acceptance
    logic [31:0] mem [64];
    logic        stall = 1'b0;
    logic [1:0]  cyc = '0;
    assign mem_req_ready = !stall || (cyc == 2'd0);
    always @(posedge clk) begin
        cyc <= cyc + 2'd1;
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem[mem_req_addr[7:2]];
        end
    end

    // Port monitor: logs writes, counts requests and protocol violations
    logic        log_clr = 1'b0;
    int          nlog = 0, nreq = 0, viol = 0;
    logic        pend = 1'b0;
    logic [19:0] la [16];
    logic [31:0] ld [16];
    logic [3:0]  lb [16];
    always @(posedge clk) begin
        if (log_clr) begin
            nlog <= 0;
            nreq <= 0;
        end else begin
            if (rw_valid && nlog < 16) begin
                la[nlog] <= rw_addr;
                ld[nlog] <= rw_data;
                lb[nlog] <= rw_be;
                nlog <= nlog + 1;
            end
            if (mem_req_valid && mem_req_ready) nreq <= nreq + 1;
        end
        if (rw_valid && !busy) viol <= viol + 1;
        if (mem_req_valid && mem_req_ready && pend) viol <= viol + 1;
        if (mem_req_valid && mem_req_addr[1:0] != 2'b00) viol <= viol + 1;
        if (mem_req_valid && mem_req_ready) pend <= 1'b1;
        else if (mem_rsp_valid) pend <= 1'b0;
    end

    int n_tests = 0, n_fail = 0;

    task automatic chk(input logic ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_en(input logic v);
        en_wr = 1'b1; en_val = v; tick(); en_wr = 1'b0;
    endtask

    task automatic set_head(input logic [PW-1:0] p);
        head_wr = 1'b1; ptr_val = p; tick(); head_wr = 1'b0;
    endtask

    task automatic set_tail(input logic [PW-1:0] p);
        tail_wr = 1'b1; ptr_val = p; tick(); tail_wr = 1'b0;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    endtask

    task automatic clear_log();
        log_clr = 1'b1; tick(); log_clr = 1'b0;
    endtask

    task automatic wait_idle();
        int k = 0;
        while (busy && k < 3000) begin tick(); k++; end
        chk(!busy, "R2 busy drops after drain", 64'(busy), 64'd0);
    endtask

    task automatic run_prog(input logic [PW-1:0] t);
        clear_log(); set_en(1'b1); set_head('0); set_tail(t); wait_idle();
    endtask

    // Direct-write vectors: {offset[19:0], byte enables[3:0], data[31:0]}
    localparam logic [55:0] DVEC [6] = '{
        56'h00100_F_12345678, 56'hFFFFF_1_A5A50001, 56'h00004_0_0BADF00D,
        56'h70A0C_6_FFFFFFFF, 56'h00000_8_00000000, 56'h12345_C_80000001
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(!busy, "R1 busy after reset", 64'(busy), 0);
        chk(!err, "R1 err after reset", 64'(err), 0);
        chk(!mem_req_valid && !rw_valid, "R1 no request or write after reset",
            64'({mem_req_valid, rw_valid}), 0);

        // R3 / R2 table of single direct writes, zero fill to a 64-byte tail
        for (int i = 0; i < 6; i++) begin
            clear_mem();
            mem[0] = DVEC[i][31:0];
            mem[1] = {8'h01, DVEC[i][35:32], DVEC[i][55:36]};
            run_prog(16'd64);
            chk(nlog == 1, "R3 one write per direct command", 64'(nlog), 1);
            chk(la[0] == DVEC[i][55:36] && lb[0] == DVEC[i][35:32] && ld[0] == DVEC[i][31:0],
                "R3 direct write fields", {la[0], lb[0], ld[0]}, DVEC[i]);
            chk(nreq == 16, "R2 words read head to tail", 64'(nreq), 16);
        end

        // R4 odd count with pad, followed by a direct write
        clear_mem();
        mem[0] = 32'd3; mem[1] = {8'h09, 4'h0, 20'h00300};
        mem[2] = 32'h11; mem[3] = 32'h22; mem[4] = 32'h33; mem[5] = 32'h0;
        mem[6] = 32'h77; mem[7] = {8'h01, 4'h3, 20'h00400};
        run_prog(16'd64);
        chk(nlog == 4, "R4 odd count write total", 64'(nlog), 4);
        chk(la[0] == 20'h300 && la[1] == 20'h300 && la[2] == 20'h300 && lb[2] == 4'hF,
            "R4 all data to one offset", 64'(la[2]), 64'h300);
        chk(ld[0] == 32'h11 && ld[1] == 32'h22 && ld[2] == 32'h33, "R4 data order",
            64'(ld[2]), 64'h33);
        chk(la[3] == 20'h400 && ld[3] == 32'h77 && lb[3] == 4'h3, "R4 pad skipped then next command",
            64'(la[3]), 64'h400);

        // R4 even count, no pad
        clear_mem();
        mem[0] = 32'd2; mem[1] = {8'h09, 4'h0, 20'h00500};
        mem[2] = 32'hAA; mem[3] = 32'hBB;
        mem[4] = 32'hCC; mem[5] = {8'h01, 4'hF, 20'h00600};
        run_prog(16'd64);
        chk(nlog == 3, "R4 even count write total", 64'(nlog), 3);
        chk(la[1] == 20'h500 && ld[1] == 32'hBB && la[2] == 20'h600 && ld[2] == 32'hCC,
            "R4 even count sequence", 64'(la[2]), 64'h600);

        // R5 zero opcode skipped
        clear_mem();
        mem[0] = 32'hDEADBEEF; mem[1] = 32'h00F12345;
        mem[2] = 32'h99; mem[3] = {8'h01, 4'hF, 20'h00700};
        run_prog(16'd64);
        chk(nlog == 1 && la[0] == 20'h700 && ld[0] == 32'h99, "R5 no-op pair skipped",
            64'(nlog), 1);

        // R6 unknown opcode
        clear_mem();
        mem[0] = 32'h1; mem[1] = 32'h55000000;
        mem[2] = 32'h2; mem[3] = {8'h01, 4'hF, 20'h00800};
        run_prog(16'd64);
        chk(err, "R6 err set on unknown opcode", 64'(err), 1);
        chk(nlog == 0, "R6 no write on unknown opcode", 64'(nlog), 0);
        chk(nreq == 2, "R6 fetch stops after bad header", 64'(nreq), 2);
        set_tail(16'd64);
        tick();
        chk(!busy && err, "R6 err blocks new run", 64'({busy, err}), 1);
        set_en(1'b0);
        chk(!err, "R6 err cleared by disable", 64'(err), 0);

        // R8 tail write while disabled or equal to head
        clear_log();
        set_head('0);
        set_tail(16'd64);
        tick();
        chk(!busy && nreq == 0, "R8 disabled tail write does not start", 64'(nreq), 0);
        set_en(1'b1);
        set_tail(16'd0);
        tick();
        chk(!busy && nreq == 0, "R8 tail equal head does not start", 64'(busy), 0);

        // R7 control writes while busy are ignored
        clear_mem();
        mem[0] = 32'hCAFE0001; mem[1] = {8'h01, 4'hF, 20'h00010};
        mem[2] = 32'hCAFE0002; mem[3] = {8'h01, 4'hF, 20'h00020};
        stall = 1'b1;
        clear_log();
        set_head('0);
        set_tail(16'd8);
        chk(busy, "R7 run started", 64'(busy), 1);
        set_tail(16'd64);
        set_head(16'd32);
        set_en(1'b0);
        wait_idle();
        chk(nlog == 1 && la[0] == 20'h10, "R7 tail write during run ignored", 64'(nlog), 1);
        stall = 1'b0;
        set_tail(16'd16);
        wait_idle();
        chk(nlog == 2 && la[1] == 20'h20 && ld[1] == 32'hCAFE0002,
            "R7 head and enable kept through busy writes", 64'(nlog), 2);

        // R9 R10 port discipline seen by the monitor
        chk(viol == 0, "R9 R10 memory and write port discipline", 64'(viol), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule